// File: doc/BRIEF.md
# SIMD Operand Fault Checker

This block decides, in one evaluation, whether a 128-bit packed-integer vector instruction may proceed or which architectural exception it must raise. It looks at the processor operating mode, three control-register bits, a feature-present bit, the instruction's prefix flags and, for memory forms, the effective address together with status flags from the address path: canonical form, segment-limit violation, stack-segment reference and page fault. It reports one exception, the one with the highest priority: undefined opcode first, then device not available, then the general-protection and stack-segment group, then page fault.

The decision logic is combinational. A parameter adds an output register, which gives one cycle of latency and an asynchronous active-low reset that clears the outputs. Translating addresses and delivering the exception are left to the surrounding pipeline. The block only classifies the fault.

The exception code is three bits wide. None = 0, undefined opcode = 1, device not available = 2, general protection = 3, stack segment = 4, page fault = 5. The operating mode is also a three-bit code. Real = 0, virtual-8086 = 1, protected = 2, compatibility = 3, 64-bit = 4. Codes 5 to 7 are reserved, and the block treats them like protected mode.

Top module: `simd_fault_checker`

## Requirements
- R1: The output is undefined opcode (code 1) when the emulation bit (CR0 bit 2) is 1, when the OS vector-support bit (CR4 bit 9) is 0, or when the feature-present bit is 0. This overrides every other fault.
- R2: The output is undefined opcode (code 1) when the lock prefix flag, the F3h repeat flag or the F2h repeat flag is set.
- R3: When no undefined-opcode condition holds and the task-switched bit (CR0 bit 3) is 1, the output is device not available (code 2). This holds whatever the memory inputs are.
- R4: For a memory operand whose effective address bits [3:0] are not all zero, the output is general protection (code 3) in every mode. This check comes before the stack-segment, limit, range and page-fault checks.
- R5: In 64-bit mode (mode 4), an aligned memory operand with the canonical flag clear gives stack segment (code 4) when the stack flag is set, and general protection (code 3) otherwise. The segment-limit flag is ignored in this mode.
- R6: In real mode (0) and virtual-8086 mode (1), an aligned memory operand whose last byte (address + 15) lies above 0xFFFF gives general protection (code 3). The canonical and segment-limit flags are ignored in these modes.
- R7: In protected mode (2), compatibility mode (3) and the reserved mode codes 5 to 7, an aligned memory operand with the segment-limit flag set gives stack segment (code 4) when the stack flag is set, and general protection (code 3) otherwise. The canonical flag is ignored in these modes.
- R8: A page fault indication on a memory operand with no higher fault gives page fault (code 5) in every mode except real mode (0). In real mode it is ignored.
- R9: When the memory-operand flag is 0, the address, canonical, limit, stack and page-fault inputs have no effect on the outputs.
- R10: With no fault, fault_valid_o is 0 and fault_code_o is 0. With a fault, fault_valid_o is 1. err_code_o is 0 in every case, including general protection and stack segment.
- R11: With REG_OUT = 1 (the default), the outputs reflect the inputs present at the previous rising clock edge. While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operating mode code (0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit) |
| cr0_emul_i | input | 1 | Emulation control bit (CR0 bit 2) |
| cr0_task_sw_i | input | 1 | Task-switched control bit (CR0 bit 3) |
| cr4_simd_os_i | input | 1 | OS vector state support bit (CR4 bit 9) |
| feat_en_i | input | 1 | Instruction feature present |
| pfx_lock_i | input | 1 | Lock prefix seen |
| pfx_rep_i | input | 1 | F3h repeat prefix seen |
| pfx_repne_i | input | 1 | F2h repeat prefix seen |
| mem_op_i | input | 1 | Instruction has a memory operand |
| eff_addr_i | input | ADDR_W | Effective address of the operand |
| addr_canon_i | input | 1 | Address is in canonical form |
| seg_limit_viol_i | input | 1 | Segment limit or access check failed |
| stack_seg_i | input | 1 | Operand references the stack segment |
| page_fault_i | input | 1 | Translation reported a page fault |
| fault_valid_o | output | 1 | An exception is raised |
| fault_code_o | output | 3 | Exception code |
| err_code_o | output | ERR_W | Error code pushed with the exception (always 0) |

## Verification
Every cycle, the assertions check the top of the priority order. Any undefined-opcode condition at the ports yields code 1 a cycle later. Task-switched without an undefined-opcode condition yields code 2. A misaligned memory operand below those two yields code 3. A register form never faults past those two. Real mode never reports a page fault, and the valid bit always agrees with the code. The per-mode treatment of the canonical, limit and address-range inputs, and the stack-versus-general choice, are shown only by the bench. The bench also shows reset clearing the outputs and the one-cycle latency. It covers these with directed cases at the range edge 0xFFF0 and 0xFFF1, and with seeded random mixes checked against its own model.

// File: rtl/simd_fault_pkg.sv
package simd_fault_pkg;

    // Exception codes reported on fault_code_o
    typedef enum logic [2:0] {
        EXC_NONE = 3'd0,
        EXC_UD   = 3'd1,
        EXC_NM   = 3'd2,
        EXC_GP   = 3'd3,
        EXC_SS   = 3'd4,
        EXC_PF   = 3'd5
    } exc_e;

    // Operating mode input codes
    localparam logic [2:0] MODE_REAL   = 3'd0;
    localparam logic [2:0] MODE_V86    = 3'd1;
    localparam logic [2:0] MODE_PROT   = 3'd2;
    localparam logic [2:0] MODE_COMPAT = 3'd3;
    localparam logic [2:0] MODE_LONG   = 3'd4;

    // Address-check rule family selected by the mode
    typedef enum logic [1:0] {
        RULE_RANGE16 = 2'd0,   // 16-bit linear range check
        RULE_SEGMENT = 2'd1,   // segment limit check
        RULE_FLAT    = 2'd2    // canonical form check
    } rule_e;

    typedef struct packed {
        rule_e rule;
        logic  pf_en;
    } mode_cfg_t;

    function automatic mode_cfg_t decode_mode(input logic [2:0] m);
        mode_cfg_t c;
        unique case (m)
            MODE_REAL: begin c.rule = RULE_RANGE16; c.pf_en = 1'b0; end
            MODE_V86:  begin c.rule = RULE_RANGE16; c.pf_en = 1'b1; end
            MODE_LONG: begin c.rule = RULE_FLAT;    c.pf_en = 1'b1; end
            default:   begin c.rule = RULE_SEGMENT; c.pf_en = 1'b1; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/simd_fault_prereq.sv
module simd_fault_prereq (
    input  logic cr0_emul_i,
    input  logic cr0_task_sw_i,
    input  logic cr4_simd_os_i,
    input  logic feat_en_i,
    input  logic pfx_lock_i,
    input  logic pfx_rep_i,
    input  logic pfx_repne_i,
    output logic ud_hit_o,
    output logic nm_hit_o
);

    logic ctrl_bad;
    logic pfx_bad;

    always_comb begin
        ctrl_bad = cr0_emul_i | ~cr4_simd_os_i | ~feat_en_i;
        pfx_bad  = pfx_lock_i | pfx_rep_i | pfx_repne_i;
        ud_hit_o = ctrl_bad | pfx_bad;
        nm_hit_o = cr0_task_sw_i;
    end

endmodule

// File: rtl/simd_fault_memchk.sv
module simd_fault_memchk
    import simd_fault_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int OP_BYTES = 16,
    parameter int RANGE_TOP = 32'h0000_FFFF
) (
    input  logic [2:0]        mode_i,
    input  logic              mem_op_i,
    input  logic [ADDR_W-1:0] eff_addr_i,
    input  logic              addr_canon_i,
    input  logic              seg_limit_viol_i,
    input  logic              stack_seg_i,
    input  logic              page_fault_i,
    output logic              addr_hit_o,
    output exc_e              addr_code_o,
    output logic              pf_hit_o
);

    localparam int ALIGN_BITS = $clog2(OP_BYTES);
    localparam int EXT_W      = ADDR_W + 1;

    mode_cfg_t        cfg;
    logic             misalign;
    logic [EXT_W-1:0] last_byte;
    logic             out_of_range;
    logic             rule_hit;

    always_comb begin
        cfg          = decode_mode(mode_i);
        misalign     = |eff_addr_i[ALIGN_BITS-1:0];
        last_byte    = {1'b0, eff_addr_i} + EXT_W'(OP_BYTES - 1);
        out_of_range = last_byte > EXT_W'(RANGE_TOP);

        rule_hit = 1'b0;
        unique case (cfg.rule)
            RULE_RANGE16: rule_hit = out_of_range;
            RULE_SEGMENT: rule_hit = seg_limit_viol_i;
            RULE_FLAT:    rule_hit = ~addr_canon_i;
            default:      rule_hit = 1'b0;
        endcase

        addr_hit_o  = 1'b0;
        addr_code_o = EXC_NONE;
        if (mem_op_i) begin
            if (misalign) begin
                addr_hit_o  = 1'b1;
                addr_code_o = EXC_GP;
            end else if (rule_hit) begin
                addr_hit_o  = 1'b1;
                // range rule never uses the stack distinction
                addr_code_o = (stack_seg_i && cfg.rule != RULE_RANGE16) ? EXC_SS : EXC_GP;
            end
        end
        pf_hit_o = mem_op_i & cfg.pf_en & page_fault_i;
    end

endmodule

// File: rtl/simd_fault_arbiter.sv
module simd_fault_arbiter
    import simd_fault_pkg::*;
(
    input  logic ud_hit_i,
    input  logic nm_hit_i,
    input  logic addr_hit_i,
    input  exc_e addr_code_i,
    input  logic pf_hit_i,
    output logic valid_o,
    output exc_e code_o
);

    always_comb begin
        if (ud_hit_i)        code_o = EXC_UD;
        else if (nm_hit_i)   code_o = EXC_NM;
        else if (addr_hit_i) code_o = addr_code_i;
        else if (pf_hit_i)   code_o = EXC_PF;
        else                 code_o = EXC_NONE;
        valid_o = ud_hit_i | nm_hit_i | addr_hit_i | pf_hit_i;
    end

endmodule

// File: rtl/simd_fault_checker.sv
module simd_fault_checker
    import simd_fault_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int ERR_W   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              cr0_emul_i,
    input  logic              cr0_task_sw_i,
    input  logic              cr4_simd_os_i,
    input  logic              feat_en_i,
    input  logic              pfx_lock_i,
    input  logic              pfx_rep_i,
    input  logic              pfx_repne_i,
    input  logic              mem_op_i,
    input  logic [ADDR_W-1:0] eff_addr_i,
    input  logic              addr_canon_i,
    input  logic              seg_limit_viol_i,
    input  logic              stack_seg_i,
    input  logic              page_fault_i,
    output logic              fault_valid_o,
    output logic [2:0]        fault_code_o,
    output logic [ERR_W-1:0]  err_code_o
);

    logic ud_hit;
    logic nm_hit;
    logic addr_hit;
    exc_e addr_code;
    logic pf_hit;
    logic nxt_valid;
    exc_e nxt_code;

    simd_fault_prereq u_prereq (
        .cr0_emul_i    (cr0_emul_i),
        .cr0_task_sw_i (cr0_task_sw_i),
        .cr4_simd_os_i (cr4_simd_os_i),
        .feat_en_i     (feat_en_i),
        .pfx_lock_i    (pfx_lock_i),
        .pfx_rep_i     (pfx_rep_i),
        .pfx_repne_i   (pfx_repne_i),
        .ud_hit_o      (ud_hit),
        .nm_hit_o      (nm_hit)
    );

    simd_fault_memchk #(.ADDR_W(ADDR_W)) u_memchk (
        .mode_i           (mode_i),
        .mem_op_i         (mem_op_i),
        .eff_addr_i       (eff_addr_i),
        .addr_canon_i     (addr_canon_i),
        .seg_limit_viol_i (seg_limit_viol_i),
        .stack_seg_i      (stack_seg_i),
        .page_fault_i     (page_fault_i),
        .addr_hit_o       (addr_hit),
        .addr_code_o      (addr_code),
        .pf_hit_o         (pf_hit)
    );

    simd_fault_arbiter u_arb (
        .ud_hit_i    (ud_hit),
        .nm_hit_i    (nm_hit),
        .addr_hit_i  (addr_hit),
        .addr_code_i (addr_code),
        .pf_hit_i    (pf_hit),
        .valid_o     (nxt_valid),
        .code_o      (nxt_code)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    fault_valid_o <= 1'b0;
                    fault_code_o  <= 3'd0;
                end else begin
                    fault_valid_o <= nxt_valid;
                    fault_code_o  <= nxt_code;
                end
            end

            // R1 R2
            ud_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cr0_emul_i || !cr4_simd_os_i || !feat_en_i ||
                 pfx_lock_i || pfx_rep_i || pfx_repne_i) |=> (fault_code_o == EXC_UD));

            // R3
            nm_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ud_hit && cr0_task_sw_i) |=> (fault_code_o == EXC_NM));

            // R4
            misalign_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ud_hit && !cr0_task_sw_i && mem_op_i && (eff_addr_i[3:0] != 4'd0))
                |=> (fault_code_o == EXC_GP));

            // R9
            reg_form_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ud_hit && !nm_hit && !mem_op_i) |=> (!fault_valid_o && fault_code_o == EXC_NONE));

            // R8
            real_no_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == MODE_REAL) |=> (fault_code_o != EXC_PF));

            // R10
            valid_code_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fault_valid_o == (fault_code_o != 3'd0));
        end else begin : g_comb
            always_comb begin
                fault_valid_o = nxt_valid;
                fault_code_o  = nxt_code;
            end
        end
    endgenerate

    // #GP(0) and #SS(0) carry a zero error code; #UD, #NM carry none
    assign err_code_o = '0;

endmodule

// File: tb/sim_simd_fault_checker.sv
module sim_simd_fault_checker;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 64;
    localparam int ERR_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        mode_i = 3'd0;
    logic              cr0_emul_i = 1'b0;
    logic              cr0_task_sw_i = 1'b0;
    logic              cr4_simd_os_i = 1'b1;
    logic              feat_en_i = 1'b1;
    logic              pfx_lock_i = 1'b0;
    logic              pfx_rep_i = 1'b0;
    logic              pfx_repne_i = 1'b0;
    logic              mem_op_i = 1'b0;
    logic [ADDR_W-1:0] eff_addr_i = '0;
    logic              addr_canon_i = 1'b1;
    logic              seg_limit_viol_i = 1'b0;
    logic              stack_seg_i = 1'b0;
    logic              page_fault_i = 1'b0;
    logic              fault_valid_o;
    logic [2:0]        fault_code_o;
    logic [ERR_W-1:0]  err_code_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    simd_fault_checker #(.ADDR_W(ADDR_W), .ERR_W(ERR_W), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .cr0_emul_i(cr0_emul_i), .cr0_task_sw_i(cr0_task_sw_i),
        .cr4_simd_os_i(cr4_simd_os_i), .feat_en_i(feat_en_i),
        .pfx_lock_i(pfx_lock_i), .pfx_rep_i(pfx_rep_i), .pfx_repne_i(pfx_repne_i),
        .mem_op_i(mem_op_i), .eff_addr_i(eff_addr_i), .addr_canon_i(addr_canon_i),
        .seg_limit_viol_i(seg_limit_viol_i), .stack_seg_i(stack_seg_i),
        .page_fault_i(page_fault_i), .fault_valid_o(fault_valid_o),
        .fault_code_o(fault_code_o), .err_code_o(err_code_o)
    );

    // Reference model written from the requirements
    task automatic model(output logic [2:0] code, output string tag);
        logic [ADDR_W:0] last;
        logic rng, rule;
        last = {1'b0, eff_addr_i} + 65'd15;
        rng  = last > 65'h0FFFF;
        code = 3'd0;
        tag  = "R10";
        if (cr0_emul_i || !cr4_simd_os_i || !feat_en_i) begin
            code = 3'd1; tag = "R1";
        end else if (pfx_lock_i || pfx_rep_i || pfx_repne_i) begin
            code = 3'd1; tag = "R2";
        end else if (cr0_task_sw_i) begin
            code = 3'd2; tag = "R3";
        end else if (!mem_op_i) begin
            code = 3'd0; tag = "R9";
        end else if (eff_addr_i[3:0] != 4'd0) begin
            code = 3'd3; tag = "R4";
        end else begin
            if (mode_i == 3'd0 || mode_i == 3'd1) begin
                rule = rng;
                if (rule) begin code = 3'd3; tag = "R6"; end
            end else if (mode_i == 3'd4) begin
                rule = !addr_canon_i;
                if (rule) begin code = stack_seg_i ? 3'd4 : 3'd3; tag = "R5"; end
            end else begin
                rule = seg_limit_viol_i;
                if (rule) begin code = stack_seg_i ? 3'd4 : 3'd3; tag = "R7"; end
            end
            if (!rule && page_fault_i && mode_i != 3'd0) begin
                code = 3'd5; tag = "R8";
            end else if (!rule && mode_i == 3'd0 && page_fault_i) begin
                tag = "R8";
            end
        end
    endtask

    task automatic check_out(input logic [2:0] exp_code, input string tag);
        n_checks++;
        if (fault_code_o !== exp_code || fault_valid_o !== (exp_code != 3'd0) ||
            err_code_o !== '0) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b code=%0d err=%0h, expected valid=%0b code=%0d err=0",
                     tag, fault_valid_o, fault_code_o, err_code_o, (exp_code != 3'd0), exp_code);
        end
    endtask

    task automatic set_clean();
        mode_i = 3'd2; cr0_emul_i = 0; cr0_task_sw_i = 0; cr4_simd_os_i = 1; feat_en_i = 1;
        pfx_lock_i = 0; pfx_rep_i = 0; pfx_repne_i = 0; mem_op_i = 1; eff_addr_i = 64'h1000;
        addr_canon_i = 1; seg_limit_viol_i = 0; stack_seg_i = 0; page_fault_i = 0;
    endtask

    // Inputs set at the falling edge; result registered at the next rising edge
    task automatic run_vec(input logic [2:0] exp_code, input string tag);
        @(posedge clk);
        #1;
        check_out(exp_code, tag);
        @(negedge clk);
    endtask

    task automatic run_model();
        logic [2:0] c;
        string t;
        model(c, t);
        run_vec(c, t);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected end of run");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned s;
        s = $urandom(32'h0000_5EED);
        set_clean();
        mem_op_i = 1; eff_addr_i = 64'h3; cr0_emul_i = 1;
        repeat (3) @(posedge clk);
        #1;
        check_out(3'd0, "R11 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R1 control bits
        set_clean(); cr0_emul_i = 1; cr0_task_sw_i = 1; eff_addr_i = 64'h7; run_vec(3'd1, "R1 emul");
        set_clean(); cr4_simd_os_i = 0; run_vec(3'd1, "R1 os bit");
        set_clean(); feat_en_i = 0; page_fault_i = 1; run_vec(3'd1, "R1 feature");
        // R2 prefixes
        set_clean(); pfx_lock_i = 1; run_vec(3'd1, "R2 lock");
        set_clean(); pfx_rep_i = 1; cr0_task_sw_i = 1; run_vec(3'd1, "R2 rep");
        set_clean(); pfx_repne_i = 1; run_vec(3'd1, "R2 repne");
        // R3 and R11 latency: output holds old value until the edge
        set_clean(); run_vec(3'd0, "R10 clean");
        cr0_task_sw_i = 1; eff_addr_i = 64'h9; page_fault_i = 1;
        #1; check_out(3'd0, "R11 latency");
        run_vec(3'd2, "R3 task switched");
        // R4 misalignment in each mode
        for (int m = 0; m < 5; m++) begin
            set_clean(); mode_i = 3'(m); eff_addr_i = 64'h8; seg_limit_viol_i = 1;
            addr_canon_i = 0; stack_seg_i = 1; page_fault_i = 1;
            run_vec(3'd3, "R4 misaligned");
        end
        // R5 64-bit canonical
        set_clean(); mode_i = 3'd4; addr_canon_i = 0; stack_seg_i = 1; run_vec(3'd4, "R5 stack");
        set_clean(); mode_i = 3'd4; addr_canon_i = 0; run_vec(3'd3, "R5 data");
        set_clean(); mode_i = 3'd4; seg_limit_viol_i = 1; run_vec(3'd0, "R5 limit ignored");
        // R6 range edge
        set_clean(); mode_i = 3'd0; eff_addr_i = 64'hFFF0; seg_limit_viol_i = 1; addr_canon_i = 0;
        run_vec(3'd0, "R6 last in range");
        set_clean(); mode_i = 3'd0; eff_addr_i = 64'h10000; stack_seg_i = 1; run_vec(3'd3, "R6 real over");
        set_clean(); mode_i = 3'd1; eff_addr_i = 64'hFFFF_FFFF_FFFF_FFF0; run_vec(3'd3, "R6 v86 wrap");
        set_clean(); mode_i = 3'd1; eff_addr_i = 64'hFFF1; run_vec(3'd3, "R6 v86 misaligned edge");
        // R7 segment limit
        set_clean(); mode_i = 3'd2; seg_limit_viol_i = 1; stack_seg_i = 1; run_vec(3'd4, "R7 prot stack");
        set_clean(); mode_i = 3'd3; seg_limit_viol_i = 1; run_vec(3'd3, "R7 compat data");
        set_clean(); mode_i = 3'd6; seg_limit_viol_i = 1; stack_seg_i = 1; run_vec(3'd4, "R7 reserved");
        set_clean(); mode_i = 3'd2; addr_canon_i = 0; run_vec(3'd0, "R7 canon ignored");
        // R8 page fault
        set_clean(); mode_i = 3'd0; eff_addr_i = 64'h100; page_fault_i = 1; run_vec(3'd0, "R8 real ignored");
        set_clean(); mode_i = 3'd1; eff_addr_i = 64'h100; page_fault_i = 1; run_vec(3'd5, "R8 v86");
        set_clean(); mode_i = 3'd4; page_fault_i = 1; run_vec(3'd5, "R8 long");
        set_clean(); mode_i = 3'd2; page_fault_i = 1; seg_limit_viol_i = 1; run_vec(3'd3, "R8 below limit");
        // R9 register form
        set_clean(); mem_op_i = 0; eff_addr_i = 64'h5; page_fault_i = 1; seg_limit_viol_i = 1;
        run_vec(3'd0, "R9 reg form");

        // Seeded random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned sel;
            mode_i           = 3'($urandom % 8);
            cr0_emul_i       = ($urandom % 10) == 0;
            cr4_simd_os_i    = ($urandom % 10) != 0;
            feat_en_i        = ($urandom % 10) != 0;
            pfx_lock_i       = ($urandom % 16) == 0;
            pfx_rep_i        = ($urandom % 16) == 0;
            pfx_repne_i      = ($urandom % 16) == 0;
            cr0_task_sw_i    = ($urandom % 6) == 0;
            mem_op_i         = ($urandom % 4) != 0;
            addr_canon_i     = ($urandom % 4) != 0;
            seg_limit_viol_i = ($urandom % 4) == 0;
            stack_seg_i      = ($urandom % 2) == 0;
            page_fault_i     = ($urandom % 4) == 0;
            sel = $urandom % 3;
            if (sel == 0)      eff_addr_i = {$urandom, $urandom};
            else if (sel == 1) eff_addr_i = 64'($urandom % 32'h10000);
            else               eff_addr_i = 64'h0FFE0 + 64'($urandom % 64);
            if (($urandom % 4) != 0) eff_addr_i[3:0] = 4'd0;
            run_model();
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule